// File: doc/BRIEF.md
# Attribute Palette and Color Lookup Output Stage

This block is the last stage of a 16-color planar video pipeline. It takes a 4-bit pixel code and turns it into 6-bit red, green and blue levels for the display. The pixel code is first masked by a plane-enable mask. It then goes through a 16-entry attribute palette, which maps it to an index into a 256-entry color table. Each color-table entry holds 6 bits per channel. A fine-pan register delays the pixel stream by 0 to 7 pixel clocks. Its value takes effect at each line-start pulse.

Software programs the block over a narrow byte bus with three addresses. The attribute address is shared by index writes and data writes. A toggle decides which of the two the next write is. Reading the status register forces the toggle back to its index state. Bit 5 of every attribute index byte switches video output on or off. The color table is loaded by writing a start index, then writing red, green and blue in that order. The index steps forward by one after each blue write.

While the blank input is high, the output shows the color-table entry named by the overscan register. While video is switched off, the output is black.

Top module: `attr_dac_path`

The attribute toggle is a two-state machine. In state AF_INDEX, an attribute write goes to AF_INDEX -> AF_DATA. In state AF_DATA, an attribute write goes to AF_DATA -> AF_INDEX. A status read from either state goes to AF_INDEX. The color-table loader is a three-state machine. A data write moves it CH_RED -> CH_GRN -> CH_BLU -> CH_RED. A write-index write from any state moves it to CH_RED.

## Requirements
- R1: After reset, the three color outputs are 0 and video is off. The attribute toggle is in its index state, the plane mask is 4'hF, the fine pan is 0 and the loader waits for red.
- R2: A status read (stat_rd high) leaves the attribute toggle in its index state. This holds even when an attribute write occurs in the same cycle. That write is still handled according to the state the toggle was in.
- R3: Writes to bus address 0 alternate between index and data. The low 5 bits of an index byte select a register. Data for registers 0x00..0x0F sets the 6-bit palette entry. Register 0x11 takes 8 bits of overscan index. Register 0x12 takes a 4-bit plane mask. Register 0x13 takes a 3-bit pan value. Data for 0x10 and 0x14..0x1F is ignored. A write to bus address 3 is ignored.
- R4: Bit 5 of an attribute index byte is the video enable. When it is 0, the outputs are black from the second rising edge after the write. Writing 0x20 alone turns video back on.
- R5: With pan 0, the output is table[palette[pixel & mask]] three clock edges after the pixel is presented. The palette value is zero-extended to form the table index.
- R6: The pan register is copied into the active pan only on a line_start pulse. The pixel latency is 3 + active pan edges.
- R7: Bus address 1 sets the table write index. Each write to address 2 loads the next channel in the order red, green, blue, using the low 6 bits. The blue write stores the whole entry and increments the index, with 255 wrapping to 0.
- R8: A write to address 1 restarts the channel order at red and discards any partly written entry.
- R9: While blank_in is high, the output is table[overscan], with the same 3-edge latency as the pixel path.
- R10: Video off takes priority over blanking: the output stays black even while blank_in is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | 0 attribute, 1 table write index, 2 table data, 3 unused |
| bus_wdata | input | 8 | Write data |
| stat_rd | input | 1 | Status-register read strobe |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| blank_in | input | 1 | Blanking interval |
| pix_in | input | 4 | Planar pixel code |
| red_out | output | 6 | Red level |
| grn_out | output | 6 | Green level |
| blu_out | output | 6 | Blue level |

## Verification
The bench first loads the whole color table. It adds one extra triple to prove that the index wraps into entry 0. It then sweeps all 16 pixel codes under four plane masks. It measures the edge at which the output changes for every pan value from 0 to 7. A design that applied the pan at once would fail the check where pan is written without a line_start pulse.

A status read issued together with an attribute write shows whether the toggle is forced back. If it is not, the following index byte lands in the wrong palette slot. A red write abandoned by a new index write shows whether the channel count restarts. If it does not, the colors are shifted and stored one write early.

Blanking with video off shows which of the two takes priority. Writes to the reserved attribute registers must leave both the sweep and the overscan color unchanged.

// File: rtl/avc_pkg.sv
package avc_pkg;
    typedef enum logic {
        AF_INDEX = 1'b0,
        AF_DATA  = 1'b1
    } attr_flop_e;

    typedef enum logic [1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } dac_ch_e;

    localparam logic [1:0] PORT_ATTR  = 2'd0;
    localparam logic [1:0] PORT_DIDX  = 2'd1;
    localparam logic [1:0] PORT_DDATA = 2'd2;

    localparam logic [4:0] REG_OVERSCAN = 5'h11;
    localparam logic [4:0] REG_PLANES   = 5'h12;
    localparam logic [4:0] REG_PAN      = 5'h13;

    localparam int VIDEO_ON_BIT = 5;
endpackage

// File: rtl/attr_regs.sv
module attr_regs
    import avc_pkg::*;
#(
    parameter int PIX_W  = 4,
    parameter int PAL_DW = 6,
    parameter int OVS_W  = 8,
    parameter int PAN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              wr_stb,
    input  logic [7:0]        wr_data,
    input  logic [PIX_W-1:0]  rd_idx,
    output logic [PAL_DW-1:0] rd_val,
    output logic [OVS_W-1:0]  overscan,
    output logic [PIX_W-1:0]  plane_mask,
    output logic [PAN_W-1:0]  pan_reg,
    output logic              video_on,
    output logic              in_data
);
    localparam int PAL_N = 1 << PIX_W;

    attr_flop_e flop_q, flop_d;
    logic [4:0] sel_q;
    logic [PAL_DW-1:0] pal_q [PAL_N];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) flop_q <= AF_INDEX;
        else        flop_q <= flop_d;
    end

    // next state
    always_comb begin
        flop_d = flop_q;
        unique case (flop_q)
            AF_INDEX: if (wr_stb) flop_d = AF_DATA;
            AF_DATA:  if (wr_stb) flop_d = AF_INDEX;
            default:  flop_d = AF_INDEX;
        endcase
        if (stat_rd) flop_d = AF_INDEX;
    end

    // register updates driven by the toggle state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= '0;
            video_on   <= 1'b0;
            overscan   <= '0;
            plane_mask <= '1;
            pan_reg    <= '0;
            for (int i = 0; i < PAL_N; i++) pal_q[i] <= '0;
        end else if (wr_stb) begin
            unique case (flop_q)
                AF_INDEX: begin
                    sel_q    <= wr_data[4:0];
                    video_on <= wr_data[VIDEO_ON_BIT];
                end
                AF_DATA: begin
                    if (sel_q < 5'(PAL_N))
                        pal_q[sel_q[PIX_W-1:0]] <= wr_data[PAL_DW-1:0];
                    else if (sel_q == REG_OVERSCAN)
                        overscan <= wr_data[OVS_W-1:0];
                    else if (sel_q == REG_PLANES)
                        plane_mask <= wr_data[PIX_W-1:0];
                    else if (sel_q == REG_PAN)
                        pan_reg <= wr_data[PAN_W-1:0];
                end
                default: ;
            endcase
        end
    end

    assign rd_val  = pal_q[rd_idx];
    assign in_data = (flop_q == AF_DATA);
endmodule

// File: rtl/dac_table.sv
module dac_table
    import avc_pkg::*;
#(
    parameter int CH_W  = 6,
    parameter int DAC_N = 256,
    parameter int IW    = $clog2(DAC_N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idx_stb,
    input  logic            data_stb,
    input  logic [7:0]      wr_data,
    input  logic [IW-1:0]   rd_addr,
    output logic [3*CH_W-1:0] rd_rgb,
    output logic [1:0]      ch_state,
    output logic [IW-1:0]   wr_ptr
);
    dac_ch_e ch_q, ch_d;
    logic [CH_W-1:0] red_hold, grn_hold;
    logic [3*CH_W-1:0] mem [DAC_N];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= CH_RED;
        else        ch_q <= ch_d;
    end

    // next state
    always_comb begin
        ch_d = ch_q;
        if (idx_stb) begin
            ch_d = CH_RED;
        end else if (data_stb) begin
            unique case (ch_q)
                CH_RED:  ch_d = CH_GRN;
                CH_GRN:  ch_d = CH_BLU;
                CH_BLU:  ch_d = CH_RED;
                default: ch_d = CH_RED;
            endcase
        end
    end

    // index and channel holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            red_hold <= '0;
            grn_hold <= '0;
        end else if (idx_stb) begin
            wr_ptr <= wr_data[IW-1:0];
        end else if (data_stb) begin
            unique case (ch_q)
                CH_RED:  red_hold <= wr_data[CH_W-1:0];
                CH_GRN:  grn_hold <= wr_data[CH_W-1:0];
                CH_BLU:  wr_ptr   <= wr_ptr + 1'b1;
                default: ;
            endcase
        end
    end

    // table storage, whole entry committed on blue
    always_ff @(posedge clk) begin
        if (data_stb && !idx_stb && ch_q == CH_BLU)
            mem[wr_ptr] <= {red_hold, grn_hold, wr_data[CH_W-1:0]};
    end

    assign rd_rgb   = mem[rd_addr];
    assign ch_state = ch_q;
endmodule

// File: rtl/pan_delay.sv
module pan_delay #(
    parameter int PIX_W = 4,
    parameter int TAPS  = 8,
    parameter int PAN_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic [PAN_W-1:0] pan_in,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] pix_out,
    output logic [PAN_W-1:0] pan_active
);
    logic [PIX_W-1:0] stage_q [TAPS];

    always_ff @(posedge clk) begin
        if (!rst_n)          pan_active <= '0;
        else if (line_start) pan_active <= pan_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pix_in;
    end

    for (genvar k = 1; k < TAPS; k++) begin : g_tap
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= stage_q[k-1];
        end
    end

    assign pix_out = stage_q[pan_active];
endmodule

// File: rtl/attr_dac_path.sv
module attr_dac_path
    import avc_pkg::*;
#(
    parameter int PIX_W    = 4,
    parameter int CH_W     = 6,
    parameter int DAC_N    = 256,
    parameter int PAN_TAPS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             stat_rd,
    input  logic             line_start,
    input  logic             blank_in,
    input  logic [PIX_W-1:0] pix_in,
    output logic [CH_W-1:0]  red_out,
    output logic [CH_W-1:0]  grn_out,
    output logic [CH_W-1:0]  blu_out
);
    localparam int DAC_IW = $clog2(DAC_N);
    localparam int PAN_W  = $clog2(PAN_TAPS);
    localparam int PAL_DW = CH_W;

    logic attr_stb, idx_stb, data_stb;
    logic [PAL_DW-1:0] pal_val;
    logic [DAC_IW-1:0] overscan;
    logic [PIX_W-1:0]  plane_mask, pix_panned;
    logic [PAN_W-1:0]  pan_reg, pan_active;
    logic              video_on, attr_in_data;
    logic [3*CH_W-1:0] table_rgb;
    logic [1:0]        dac_ch;
    logic [DAC_IW-1:0] dac_ptr;
    logic [DAC_IW-1:0] sel_q, rd_addr;
    logic              blank_q1, blank_q2;

    assign attr_stb = bus_wr && bus_addr == PORT_ATTR;
    assign idx_stb  = bus_wr && bus_addr == PORT_DIDX;
    assign data_stb = bus_wr && bus_addr == PORT_DDATA;

    attr_regs #(.PIX_W(PIX_W), .PAL_DW(PAL_DW), .OVS_W(DAC_IW), .PAN_W(PAN_W)) u_attr (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .wr_stb(attr_stb),
        .wr_data(bus_wdata), .rd_idx(pix_panned & plane_mask), .rd_val(pal_val),
        .overscan(overscan), .plane_mask(plane_mask), .pan_reg(pan_reg),
        .video_on(video_on), .in_data(attr_in_data)
    );

    pan_delay #(.PIX_W(PIX_W), .TAPS(PAN_TAPS), .PAN_W(PAN_W)) u_pan (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .pan_in(pan_reg),
        .pix_in(pix_in), .pix_out(pix_panned), .pan_active(pan_active)
    );

    dac_table #(.CH_W(CH_W), .DAC_N(DAC_N), .IW(DAC_IW)) u_dac (
        .clk(clk), .rst_n(rst_n), .idx_stb(idx_stb), .data_stb(data_stb),
        .wr_data(bus_wdata), .rd_addr(rd_addr), .rd_rgb(table_rgb),
        .ch_state(dac_ch), .wr_ptr(dac_ptr)
    );

    // stage two: palette result and aligned blank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            blank_q1 <= 1'b0;
            blank_q2 <= 1'b0;
        end else begin
            sel_q    <= DAC_IW'(pal_val);
            blank_q1 <= blank_in;
            blank_q2 <= blank_q1;
        end
    end

    assign rd_addr = blank_q2 ? overscan : sel_q;

    // stage three: color output
    always_ff @(posedge clk) begin
        if (!rst_n || !video_on) begin
            red_out <= '0;
            grn_out <= '0;
            blu_out <= '0;
        end else begin
            red_out <= table_rgb[3*CH_W-1:2*CH_W];
            grn_out <= table_rgb[2*CH_W-1:CH_W];
            blu_out <= table_rgb[CH_W-1:0];
        end
    end
endmodule

// File: rtl/attr_dac_path_chk.sv
module attr_dac_path_chk #(
    parameter int CH_W   = 6,
    parameter int DAC_IW = 8,
    parameter int PAN_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              stat_rd,
    input logic              line_start,
    input logic              attr_in_data,
    input logic              video_on,
    input logic [1:0]        dac_ch,
    input logic [DAC_IW-1:0] dac_ptr,
    input logic [PAN_W-1:0]  pan_active,
    input logic [CH_W-1:0]   red_out,
    input logic [CH_W-1:0]   grn_out,
    input logic [CH_W-1:0]   blu_out
);
    a_r2_status_forces_index: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !attr_in_data);

    a_r3_index_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && !attr_in_data && !stat_rd) |=> attr_in_data);

    a_r4_disabled_black: assert property (@(posedge clk) disable iff (!rst_n)
        !video_on |=> (red_out == '0 && grn_out == '0 && blu_out == '0));

    a_r7_blue_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && dac_ch == 2'd2)
            |=> (dac_ch == 2'd0 && dac_ptr == DAC_IW'($past(dac_ptr) + 1'b1)));

    a_r8_index_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> dac_ch == 2'd0);

    a_r6_pan_held: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(pan_active));
endmodule

bind attr_dac_path attr_dac_path_chk #(.CH_W(CH_W), .DAC_IW(DAC_IW), .PAN_W(PAN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .stat_rd(stat_rd),
    .line_start(line_start), .attr_in_data(attr_in_data), .video_on(video_on),
    .dac_ch(dac_ch), .dac_ptr(dac_ptr), .pan_active(pan_active),
    .red_out(red_out), .grn_out(grn_out), .blu_out(blu_out)
);

// File: tb/attr_dac_path_tb.sv
module attr_dac_path_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic stat_rd = 1'b0;
    logic line_start = 1'b0;
    logic blank_in = 1'b0;
    logic [3:0] pix_in = 4'd0;
    logic [5:0] red_out, grn_out, blu_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int tr [256];
    int tg [256];
    int tb [256];
    int pal_m [16];

    always #2 clk = ~clk;

    attr_dac_path u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .stat_rd(stat_rd), .line_start(line_start),
        .blank_in(blank_in), .pix_in(pix_in),
        .red_out(red_out), .grn_out(grn_out), .blu_out(blu_out)
    );

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic stat_read();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic attr_set(input logic [4:0] r, input logic [7:0] d);
        bus_write(2'd0, {3'b001, r});
        bus_write(2'd0, d);
    endtask

    task automatic pulse_line();
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_rgb(input string req, input int er, input int eg, input int eb);
        checks++;
        if (red_out !== 6'(er) || grn_out !== 6'(eg) || blu_out !== 6'(eb)) begin
            errors++;
            $display("FAIL %s: got %0d/%0d/%0d expected %0d/%0d/%0d",
                     req, red_out, grn_out, blu_out, er, eg, eb);
        end
    endtask

    task automatic chk_entry(input string req, input int e);
        chk_rgb(req, tr[e], tg[e], tb[e]);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            tr[i] = (i * 7 + 3) % 64;
            tg[i] = (i * 11 + 1) % 64;
            tb[i] = (i * 13 + 40) % 64;
        end
        for (int i = 0; i < 16; i++) pal_m[i] = (i * 5 + 9) % 64;

        pix_in = 4'd3;
        wait_neg(4);
        rst_n = 1'b1;
        wait_neg(4);
        // R1: video off after reset gives black
        chk_rgb("R1 reset", 0, 0, 0);

        // R7: load whole table with junk in bits 7:6
        bus_write(2'd1, 8'd0);
        for (int i = 0; i < 256; i++) begin
            bus_write(2'd2, 8'hC0 | 8'(tr[i]));
            bus_write(2'd2, 8'h80 | 8'(tg[i]));
            bus_write(2'd2, 8'h40 | 8'(tb[i]));
        end
        // R7: index wrapped 255 -> 0, extra triple lands in entry 0
        bus_write(2'd2, 8'd1); bus_write(2'd2, 8'd2); bus_write(2'd2, 8'd3);
        tr[0] = 1; tg[0] = 2; tb[0] = 3;

        // R3: palette programming, upper bits must be dropped
        for (int i = 0; i < 16; i++) attr_set(5'(i), 8'hC0 | 8'(pal_m[i]));
        attr_set(5'h11, 8'd0);
        attr_set(5'h12, 8'h0F);
        attr_set(5'h13, 8'd0);
        pulse_line();

        blank_in = 1'b1;
        wait_neg(5);
        chk_entry("R7 wrap to entry 0", 0);
        attr_set(5'h11, 8'd200);
        wait_neg(3);
        chk_entry("R9 overscan", 200);
        blank_in = 1'b0;
        wait_neg(5);

        // R5: sweep all codes under several masks
        for (int m = 0; m < 4; m++) begin
            int mask;
            mask = (m == 0) ? 15 : (m == 1) ? 5 : (m == 2) ? 10 : 0;
            attr_set(5'h12, 8'(mask));
            for (int p = 0; p < 16; p++) begin
                pix_in = 4'(p);
                wait_neg(6);
                chk_entry($sformatf("R5 pix %0d mask %0d", p, mask), pal_m[p & mask]);
            end
        end
        attr_set(5'h12, 8'h0F);

        // R6: latency for every pan value
        for (int p = 0; p < 8; p++) begin
            attr_set(5'h13, 8'(p));
            pulse_line();
            pix_in = 4'd1;
            wait_neg(14);
            pix_in = 4'd6;
            wait_neg(p + 2);
            chk_entry($sformatf("R6 pan %0d before", p), pal_m[1]);
            wait_neg(1);
            chk_entry($sformatf("R6 pan %0d edge", p), pal_m[6]);
        end
        // R6: pan written without line_start keeps active value 7
        attr_set(5'h13, 8'd0);
        pix_in = 4'd1;
        wait_neg(14);
        pix_in = 4'd6;
        wait_neg(9);
        chk_entry("R6 pan not yet applied", pal_m[1]);
        wait_neg(1);
        chk_entry("R6 pan old edge", pal_m[6]);
        pulse_line();
        pix_in = 4'd1;
        wait_neg(4);
        pix_in = 4'd6;
        wait_neg(2);
        chk_entry("R5 latency before", pal_m[1]);
        wait_neg(1);
        chk_entry("R5 latency edge", pal_m[6]);

        // R9: blank latency
        pix_in = 4'd2;
        wait_neg(6);
        blank_in = 1'b1;
        wait_neg(2);
        chk_entry("R9 blank before", pal_m[2]);
        wait_neg(1);
        chk_entry("R9 blank edge", 200);

        // R4 and R10: disable while blanked
        bus_write(2'd0, 8'h11);
        chk_entry("R4 disable not yet", 200);
        wait_neg(1);
        chk_rgb("R10 disabled over blank", 0, 0, 0);
        stat_read();
        bus_write(2'd0, 8'h20);
        wait_neg(1);
        chk_entry("R4 reenable", 200);
        blank_in = 1'b0;
        stat_read();

        // R2: status read in same cycle as an index write
        @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h25; stat_rd = 1'b1;
        @(negedge clk); bus_wr = 1'b0; stat_rd = 1'b0;
        attr_set(5'h03, 8'd50);
        pal_m[3] = 50;
        pix_in = 4'd3;
        wait_neg(6);
        chk_entry("R2 forced index slot", pal_m[3]);
        pix_in = 4'd5;
        wait_neg(6);
        chk_entry("R2 other slot untouched", pal_m[5]);

        // R2: status read between index and data
        bus_write(2'd0, 8'h27);
        stat_read();
        attr_set(5'h04, 8'd60);
        pal_m[4] = 60;
        pix_in = 4'd4;
        wait_neg(6);
        chk_entry("R2 index after read", pal_m[4]);
        pix_in = 4'd7;
        wait_neg(6);
        chk_entry("R2 slot 7 untouched", pal_m[7]);

        // R3: reserved registers and address 3 ignored
        attr_set(5'h10, 8'hFF);
        attr_set(5'h14, 8'h00);
        attr_set(5'h1F, 8'h12);
        bus_write(2'd3, 8'h07);
        attr_set(5'h09, 8'd33);
        pal_m[9] = 33;
        for (int p = 0; p < 16; p++) begin
            pix_in = 4'(p);
            wait_neg(6);
            chk_entry($sformatf("R3 after reserved pix %0d", p), pal_m[p]);
        end
        blank_in = 1'b1;
        wait_neg(4);
        chk_entry("R3 overscan kept", 200);

        // R8: partial entry discarded by index write
        attr_set(5'h11, 8'd10);
        bus_write(2'd1, 8'd10);
        bus_write(2'd2, 8'h3F);
        bus_write(2'd1, 8'd10);
        bus_write(2'd2, 8'd4); bus_write(2'd2, 8'd5); bus_write(2'd2, 8'd6);
        tr[10] = 4; tg[10] = 5; tb[10] = 6;
        wait_neg(4);
        chk_entry("R8 restart at red", 10);
        // R7: auto increment lands next triple in entry 11
        bus_write(2'd2, 8'd7); bus_write(2'd2, 8'd8); bus_write(2'd2, 8'd9);
        tr[11] = 7; tg[11] = 8; tb[11] = 9;
        attr_set(5'h11, 8'd11);
        wait_neg(4);
        chk_entry("R7 increment", 11);
        blank_in = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule